// File: doc/BRIEF.md
# Adaptive Quadrature Signal Generator

This block builds an orthogonal signal pair from a single sampled grid voltage. It is a discrete-time second-order generalized integrator. The in-phase output `alpha` follows the fundamental of the input in phase and magnitude, acting as a band-pass filter with response k·ωn·s / (s² + k·ωn·s + ωn²). The quadrature output `beta` is the same loop read at its second integrator. It acts as a low-pass filter k·ωn² / (s² + k·ωn·s + ωn²) and trails `alpha` by a quarter period at the resonant frequency.

Each sample strobe advances the loop by one sample period of 100 µs, the period of a 10 kHz sample rate. The resonant frequency is given as the product ωn·Ts. The surrounding phase-locked loop loads it from its frequency estimate, so the filter tracks the grid. The damping gain k is a build-time parameter, sqrt(2) by default. Both integrators clamp at the limits of their 24-bit state instead of wrapping.

Top module: `sogi_qsg`

## Requirements
- R1: While `rst_n` is low, `alpha` and `beta` are 0 and `out_vld` is 0. After reset the frequency coefficient is 2471, which is 2π·60·100e-6 in unsigned Q0.16. The damping gain is 5793, which is sqrt(2) in unsigned Q4.12.
- R2: A strobed sample enters the loop as a 24-bit value equal to `smp_in`·4096. The 12-bit two's-complement code sits in the upper bits of the state word.
- R3: On a strobe the in-phase state becomes alpha' = sat(alpha + floor(err·w/65536)). Here err = floor((vin − alpha)·K/4096) − beta, and all floors round toward minus infinity.
- R4: On the same strobe the quadrature state becomes beta' = sat(beta + floor(alpha'·w/65536)), using the freshly updated alpha'.
- R5: Each state saturates to the range −2^23 to 2^23−1 and never wraps. A long full-scale DC input drives `beta` to the positive limit, and a long negative full-scale DC input drives it to the negative limit.
- R6: `out_vld` is high for exactly the one clock cycle that follows each clock in which `smp_stb` was sampled high, and the state is updated in that same cycle. Consecutive strobes give consecutive valid cycles.
- R7: In cycles without a strobe, `alpha` and `beta` hold their values whatever `smp_in` does.
- R8: A cycle with `w_upd` high loads `w_in` as the new coefficient. A strobe in that same cycle still uses the old coefficient.
- R9: With a 60 Hz sinusoidal input at the default coefficient, once settled the peak of `alpha` is within 10% of the input peak. At each upward zero crossing of `alpha`, `beta` is below −0.85 times the input peak, so `beta` lags `alpha` by about 90 degrees.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe marking a new sample |
| smp_in | input | 12 | Signed grid-voltage sample |
| w_upd | input | 1 | Load strobe for the frequency coefficient |
| w_in | input | 16 | ωn·Ts, unsigned Q0.16 |
| alpha | output | 24 | In-phase component, signed, input LSB = 4096 |
| beta | output | 24 | Quadrature component, same scaling |
| out_vld | output | 1 | One-cycle pulse after each processed strobe |

## Verification
The no-wrap properties depend on two facts: the gain and the frequency coefficient are both non-negative, and the loop state changes only on a strobe. Because of this, an error of known sign can only move each integrator in that direction, or hold it at a limit. The stimulus keeps to that contract. It spaces strobes apart, or runs them back to back, changes `smp_in` to arbitrary values between strobes, and loads only coefficients that stand for real grid frequencies. Full-scale DC steps of both signs are long enough to pin `beta` at each rail.

// File: rtl/sogi_qsg.sv
module sogi_qsg #(
  parameter int IW = 12,
  parameter int SW = 24,
  parameter int KW = 16,
  parameter int KF = 12,
  parameter int WW = 16,
  parameter int WF = 16,
  parameter logic [KW-1:0] K_GAIN = 16'd5793,
  parameter logic [WW-1:0] W_RST = 16'd2471
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_stb,
  input  logic signed [IW-1:0] smp_in,
  input  logic                 w_upd,
  input  logic [WW-1:0]        w_in,
  output logic signed [SW-1:0] alpha,
  output logic signed [SW-1:0] beta,
  output logic                 out_vld
);
  localparam int FB = SW - IW;
  localparam int P1 = SW + KW + 2;
  localparam int P2 = P1 + WW + 2;
  localparam int P3 = SW + WW + 2;
  localparam logic signed [SW-1:0] SMAX = {1'b0, {(SW-1){1'b1}}};
  localparam logic signed [SW-1:0] SMIN = {1'b1, {(SW-1){1'b0}}};

  logic [WW-1:0] w_q;
  logic signed [SW-1:0] vin_s, a_nx, b_nx;
  logic signed [P1-1:0] e_x, k_x, ek;
  logic signed [P2-1:0] err_x, w_x2, asum;
  logic signed [P3-1:0] an_x, w_x3, bsum;

  assign vin_s = {smp_in, {FB{1'b0}}};

  assign e_x   = P1'(vin_s) - P1'(alpha);
  assign k_x   = P1'(K_GAIN);
  assign ek    = (e_x * k_x) >>> KF;

  assign err_x = P2'(ek) - P2'(beta);
  assign w_x2  = P2'(w_q);
  assign asum  = P2'(alpha) + ((err_x * w_x2) >>> WF);

  always_comb begin
    if (asum > P2'(SMAX))      a_nx = SMAX;
    else if (asum < P2'(SMIN)) a_nx = SMIN;
    else                       a_nx = asum[SW-1:0];
  end

  assign an_x = P3'(a_nx);
  assign w_x3 = P3'(w_q);
  assign bsum = P3'(beta) + ((an_x * w_x3) >>> WF);

  always_comb begin
    if (bsum > P3'(SMAX))      b_nx = SMAX;
    else if (bsum < P3'(SMIN)) b_nx = SMIN;
    else                       b_nx = bsum[SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alpha   <= '0;
      beta    <= '0;
      out_vld <= 1'b0;
      w_q     <= W_RST;
    end else begin
      out_vld <= smp_stb;
      if (smp_stb) begin
        alpha <= a_nx;
        beta  <= b_nx;
      end
      if (w_upd) w_q <= w_in;
    end
  end
endmodule

module sogi_qsg_chk #(
  parameter int IW = 12,
  parameter int SW = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_stb,
  input logic signed [IW-1:0] smp_in,
  input logic signed [SW-1:0] alpha,
  input logic signed [SW-1:0] beta,
  input logic                 out_vld
);
  logic signed [SW-1:0] vin_c;
  assign vin_c = {smp_in, {(SW-IW){1'b0}}};

  // R6
  vld_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> out_vld);

  // R6
  vld_only_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> !out_vld);

  // R7
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> ($stable(alpha) && $stable(beta)));

  // R3
  zero_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && smp_in == '0 && alpha == '0 && beta == '0) |=> (alpha == '0 && beta == '0));

  // R5
  alpha_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && vin_c >= alpha && beta <= 0) |=> (alpha >= $past(alpha)));

  // R5
  beta_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && alpha >= 0) |-> (beta >= $past(beta)));
endmodule

bind sogi_qsg sogi_qsg_chk #(.IW(IW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_in(smp_in),
  .alpha(alpha), .beta(beta), .out_vld(out_vld)
);

// File: tb/sim_sogi_qsg.sv
module sim_sogi_qsg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic signed [11:0] smp_in = '0;
  logic w_upd = 1'b0;
  logic [15:0] w_in = '0;
  logic signed [23:0] alpha, beta;
  logic out_vld;

  sogi_qsg u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_in(smp_in),
    .w_upd(w_upd), .w_in(w_in), .alpha(alpha), .beta(beta), .out_vld(out_vld)
  );

  always #4 clk = ~clk;

  localparam longint MAXV = (longint'(1) <<< 23) - 1;
  localparam longint MINV = -(longint'(1) <<< 23);

  int n_chk = 0;
  int n_fail = 0;
  bit chk_en = 1'b0;
  string tag = "R3";

  longint m_a = 0, m_b = 0, m_w = 2471;
  bit m_v = 1'b0;

  function automatic longint clamp(input longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    longint e, ek, er, an;
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_w = 2471; m_v = 1'b0;
    end else begin
      m_v = smp_stb;
      if (smp_stb) begin
        e  = longint'(smp_in) * 4096 - m_a;
        ek = (e * 5793) >>> 12;
        er = ek - m_b;
        an = clamp(m_a + ((er * m_w) >>> 16));
        m_b = clamp(m_b + ((an * m_w) >>> 16));
        m_a = an;
      end
      if (w_upd) m_w = longint'(w_in);
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      check(out_vld == m_v, "R6", longint'(out_vld), longint'(m_v));
      check(longint'(alpha) == m_a, {"R3 ", tag}, longint'(alpha), m_a);
      check(longint'(beta) == m_b, {"R4 ", tag}, longint'(beta), m_b);
    end
  end

  bit meas = 1'b0;
  longint amax = 0, prev_a = 0;
  int ncross = 0;
  localparam longint AMP = 1500 * 4096;

  always @(negedge clk) begin
    if (meas && out_vld) begin
      if (longint'(alpha) > amax) amax = longint'(alpha);
      if (prev_a < 0 && longint'(alpha) >= 0) begin
        ncross++;
        check(longint'(beta) < -(AMP * 85) / 100, "R9 lag", longint'(beta), -(AMP * 85) / 100);
      end
      prev_a = longint'(alpha);
    end
  end

  task automatic put(input int v, input bit upd, input logic [15:0] wv, input int gap);
    @(negedge clk);
    smp_stb = 1'b1; smp_in = 12'(v); w_upd = upd; w_in = wv;
    @(negedge clk);
    smp_stb = 1'b0; w_upd = 1'b0; smp_in = 12'($urandom);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      smp_in = 12'($urandom);
    end
  endtask

  function automatic int sine(input int n, input real f);
    return $rtoi($floor(1500.0 * $sin(2.0 * 3.14159265358979 * f * n * 1.0e-4) + 0.5));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    longint ha, hb;
    repeat (4) @(negedge clk);
    // R1
    check(alpha == '0, "R1 alpha", longint'(alpha), 0);
    check(beta == '0, "R1 beta", longint'(beta), 0);
    check(out_vld == 1'b0, "R1 vld", longint'(out_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_en = 1'b1;

    // R2: 1000*4096 from rest with the reset coefficient
    tag = "R2";
    @(negedge clk);
    smp_stb = 1'b1; smp_in = 12'sd1000;
    @(negedge clk);
    smp_stb = 1'b0;
    check(longint'(alpha) == 218421, "R2 alpha", longint'(alpha), 218421);
    check(longint'(beta) == 8235, "R2 beta", longint'(beta), 8235);
    check(out_vld == 1'b1, "R6 pulse", longint'(out_vld), 1);

    // R7
    tag = "R7";
    ha = longint'(alpha); hb = longint'(beta);
    for (int i = 0; i < 12; i++) begin
      smp_in = 12'($urandom);
      @(negedge clk);
    end
    check(longint'(alpha) == ha, "R7 alpha", longint'(alpha), ha);
    check(longint'(beta) == hb, "R7 beta", longint'(beta), hb);

    // R6 back-to-back strobes
    tag = "R6";
    smp_stb = 1'b1;
    for (int i = 0; i < 8; i++) begin
      smp_in = 12'(i * 200 - 700);
      @(negedge clk);
      check(out_vld == 1'b1, "R6 burst", longint'(out_vld), 1);
    end
    smp_stb = 1'b0;
    @(negedge clk);
    check(out_vld == 1'b0, "R6 end", longint'(out_vld), 0);

    // R5
    tag = "R5";
    for (int n = 0; n < 300; n++) put(2047, 1'b0, 16'd0, 2);
    check(longint'(beta) == MAXV, "R5 pos rail", longint'(beta), MAXV);
    for (int n = 0; n < 300; n++) put(-2048, 1'b0, 16'd0, 2);
    check(longint'(beta) == MINV, "R5 neg rail", longint'(beta), MINV);

    tag = "R3";
    for (int n = 0; n < 300; n++) put(0, 1'b0, 16'd0, 3);

    // R9
    tag = "R9";
    for (int n = 0; n < 1000; n++) begin
      if (n == 833) begin meas = 1'b1; amax = 0; prev_a = 0; ncross = 0; end
      put(sine(n, 60.0), 1'b0, 16'd0, 3);
    end
    meas = 1'b0;
    check(amax > (AMP * 90) / 100 && amax < (AMP * 110) / 100, "R9 amplitude", amax, AMP);
    check(ncross >= 1, "R9 crossing", ncross, 1);

    // R8
    tag = "R8";
    put(sine(0, 50.0), 1'b1, 16'd2059, 3);
    for (int n = 1; n < 300; n++) put(sine(n, 50.0), 1'b0, 16'd0, 3);
    @(negedge clk);
    w_upd = 1'b1; w_in = 16'd2471;
    @(negedge clk);
    w_upd = 1'b0;
    for (int n = 300; n < 400; n++) put(sine(n, 50.0), 1'b0, 16'd0, 3);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule